// File: doc/BRIEF.md
# Dual-Protocol Multiplexed Host Bus Port

This block connects an 8-bit shared address/data bus from a host processor to a 128-byte space of registers and RAM. A single mode pin chooses how the two strobe pins are read. In one mode they are a data strobe plus a read/write level. In the other they are separate active-low read and write strobes. In both modes the address is taken from the shared lines when the address strobe falls, and the chip select must be low for any access to take effect.

All bus pins are brought into the core clock domain through a synchronizer. The strobe edges and levels are then decoded into an internal read enable and a single-cycle write strobe, which carries a latched address and latched write data. The block drives the shared lines only while a qualified read is in progress; otherwise the output enable is low. A power-fail input blocks every access. A plain byte array stands in for the register file, so reads return stored data.

Top module: `rtcbus_if`

## Requirements
- R1: The mode pin `mode_mot` selects the decoding. When it is 1, `ds_pin` is a high-active data strobe and `rw_pin` is a level: 1 means read, 0 means write. When it is 0, `ds_pin` is an active-low read strobe and `rw_pin` is an active-low write strobe.
- R2: The address is captured from `ad_in[6:0]` on the falling edge of `as_pin`. Bit 7 is ignored, so 8'h85 addresses location 5.
- R3: In mode 1, while `ds_pin`=1, `rw_pin`=1 and `cs_n`=0, `ad_oe` is 1 and `ad_out` holds the byte at the latched address.
- R4: In mode 1, a falling edge of `ds_pin` with `rw_pin`=0 produces exactly one `wr_stb` pulse. That pulse carries the address and the `ad_in` value present just before the edge, and the byte is stored.
- R5: In mode 0, while `ds_pin`=0 and `cs_n`=0, `ad_oe` is 1 and `ad_out` holds the byte at the latched address.
- R6: In mode 0, a rising edge of `rw_pin` produces exactly one `wr_stb` pulse. That pulse carries the `ad_in` value present just before the edge, and the byte is stored.
- R7: With `cs_n`=1, a read does not raise `ad_oe` and a write neither pulses `wr_stb` nor changes the stored byte.
- R8: With `pwr_fail`=1, reads do not raise `ad_oe` and writes neither pulse `wr_stb` nor change storage.
- R9: After reset, `ad_oe`=0, `wr_stb`=0 and every stored byte is 0. `ad_oe` is never 1 outside a qualified read.
- R10: A write strobe edge driven between clock edges shows on `wr_stb` after exactly three rising clock edges. `wr_stb` is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mot | input | 1 | 1: strobe plus level mode, 0: separate read/write strobes |
| cs_n | input | 1 | Active-low chip select |
| as_pin | input | 1 | Address strobe; the address is captured on its falling edge |
| ds_pin | input | 1 | Data strobe (mode 1) or active-low read (mode 0) |
| rw_pin | input | 1 | Read/write level (mode 1) or active-low write (mode 0) |
| pwr_fail | input | 1 | Blocks all accesses while high |
| ad_in | input | 8 | Shared lines as seen by the block |
| ad_out | output | 8 | Read data for the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| wr_stb | output | 1 | Single-cycle internal write strobe |
| wr_addr | output | 7 | Latched access address |
| wr_data | output | 8 | Latched write data |

## Verification
Every pin passes through two synchronizer flops and one edge-detect flop, so `wr_stb` and `ad_oe` respond three rising edges after a pin changes. The stored byte is visible one edge after the strobe. The bench changes pins on falling clock edges and checks the write pulse on the third falling edge after the strobe edge, after confirming it is low on the two before. Read data is compared when the output enable first rises, and every stimulus step is held for four cycles so that the pipeline has settled before the next step.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;
  parameter int unsigned BUS_W = 8;

  typedef struct packed {
    logic             mode;
    logic             cs_n;
    logic             as;
    logic             ds;
    logic             rw;
    logic             pf;
    logic [BUS_W-1:0] ad;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);

  // idle pattern: deselected, write strobe high, power-fail held until first sample
  localparam pins_t PINS_IDLE = '{mode: 1'b0, cs_n: 1'b1, as: 1'b0, ds: 1'b0,
                                  rw: 1'b1, pf: 1'b1, ad: '0};
endpackage

// File: rtl/rtcbus_sync.sv
module rtcbus_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (i == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else        stage_q[i] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rtcbus_decode.sv
module rtcbus_decode
  import rtcbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pins_t             pins_s,
  output logic              rd_en,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  wdata
);
  pins_t             prev_q;
  logic              rd_d, rd_q;
  logic              wr_d, wr_q;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [BUS_W-1:0]  wdata_d, wdata_q;
  logic              rd_level, wr_edge_mot, wr_edge_int;

  always_comb begin
    rd_level    = pins_s.mode ? (pins_s.ds & pins_s.rw) : ~pins_s.ds;
    rd_d        = rd_level & ~pins_s.cs_n & ~pins_s.pf;
    wr_edge_mot = pins_s.mode & prev_q.ds & ~pins_s.ds & ~prev_q.rw;
    wr_edge_int = ~pins_s.mode & ~prev_q.rw & pins_s.rw;
    wr_d        = (wr_edge_mot | wr_edge_int) & ~prev_q.cs_n & ~pins_s.pf;
    addr_en     = prev_q.as & ~pins_s.as;
    addr_d      = addr_en ? prev_q.ad[ADDR_W-1:0] : addr_q;
    wdata_d     = wr_d ? prev_q.ad : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= PINS_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      prev_q  <= pins_s;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign rd_en  = rd_q;
  assign wr_stb = wr_q;
  assign addr   = addr_q;
  assign wdata  = wdata_q;
endmodule

// File: rtl/rtcbus_bytes.sv
module rtcbus_bytes #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_en;
    assign cell_en = we && (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (cell_en) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/rtcbus_if.sv
module rtcbus_if
  import rtcbus_pkg::*;
#(
  parameter int unsigned DEPTH       = 128,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_mot,
  input  logic              cs_n,
  input  logic              as_pin,
  input  logic              ds_pin,
  input  logic              rw_pin,
  input  logic              pwr_fail,
  input  logic [BUS_W-1:0]  ad_in,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data
);
  pins_t pins_raw, pins_s;
  logic  rd_en;

  always_comb begin
    pins_raw.mode = mode_mot;
    pins_raw.cs_n = cs_n;
    pins_raw.as   = as_pin;
    pins_raw.ds   = ds_pin;
    pins_raw.rw   = rw_pin;
    pins_raw.pf   = pwr_fail;
    pins_raw.ad   = ad_in;
  end

  rtcbus_sync #(
    .WIDTH  (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_s)
  );

  rtcbus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .pins_s(pins_s),
    .rd_en (rd_en),
    .wr_stb(wr_stb),
    .addr  (wr_addr),
    .wdata (wr_data)
  );

  rtcbus_bytes #(.DEPTH(DEPTH), .DATA_W(BUS_W)) u_bytes (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_stb),
    .addr (wr_addr),
    .wdata(wr_data),
    .rdata(ad_out)
  );

  assign ad_oe = rd_en;
endmodule

// File: rtl/rtcbus_if_chk.sv
module rtcbus_if_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_mot,
  input logic cs_n,
  input logic ds_pin,
  input logic rw_pin,
  input logic pwr_fail,
  input logic ad_oe,
  input logic wr_stb
);
  // R7, R9: drive only when selected three edges earlier
  a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !$past(cs_n, 3));

  // R8: power fail blocks reads and writes
  a_r8_no_read_pf: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !$past(pwr_fail, 3));
  a_r8_no_write_pf: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(pwr_fail, 3));

  // R3: strobe plus level read needs both pins high
  a_r3_mot_read_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(mode_mot, 3)) |-> ($past(ds_pin, 3) && $past(rw_pin, 3)));

  // R5: separate-strobe read needs read low
  a_r5_int_read_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !$past(mode_mot, 3)) |-> !$past(ds_pin, 3));

  // R7: write needs select one sample before the edge
  a_r7_write_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(cs_n, 4));

  // R10: write pulse one cycle wide
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

bind rtcbus_if rtcbus_if_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_mot(mode_mot),
  .cs_n    (cs_n),
  .ds_pin  (ds_pin),
  .rw_pin  (rw_pin),
  .pwr_fail(pwr_fail),
  .ad_oe   (ad_oe),
  .wr_stb  (wr_stb)
);

// File: tb/rtcbus_if_bench.sv
module rtcbus_if_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_mot, cs_n, as_pin, ds_pin, rw_pin, pwr_fail;
  logic [7:0] ad_in, ad_out, wr_data;
  logic       ad_oe, wr_stb;
  logic [6:0] wr_addr;

  always #10 clk = ~clk;

  rtcbus_if u_rtcbus_if (
    .clk(clk), .rst_n(rst_n), .mode_mot(mode_mot), .cs_n(cs_n),
    .as_pin(as_pin), .ds_pin(ds_pin), .rw_pin(rw_pin), .pwr_fail(pwr_fail),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int unsigned n_chk = 0, n_fail = 0;
  logic [7:0]  model [128];
  logic [6:0]  q_wa [$];
  logic [7:0]  q_wd [$];
  string       q_wr [$];
  logic [7:0]  q_rd [$];
  string       q_rr [$];
  logic        mon_on = 1'b0;
  logic        oe_q = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_stb) begin
        if (q_wa.size() == 0) check(1'b0, "R7/R8 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [6:0] ea; logic [7:0] ed; string er;
          ea = q_wa.pop_front(); ed = q_wd.pop_front(); er = q_wr.pop_front();
          check(wr_addr == ea && wr_data == ed, er, {wr_addr, wr_data}, {ea, ed});
        end
      end
      if (ad_oe && !oe_q) begin
        if (q_rd.size() == 0) check(1'b0, "R7/R8/R9 unexpected drive", ad_out, 0);
        else begin
          logic [7:0] ed; string er;
          ed = q_rd.pop_front(); er = q_rr.pop_front();
          check(ad_out == ed, er, ad_out, ed);
        end
      end
      oe_q = ad_oe;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle(input logic m);
    mode_mot = m; cs_n = 1'b1; as_pin = 1'b0;
    ds_pin = m ? 1'b0 : 1'b1; rw_pin = 1'b1;
    step(4);
  endtask

  task automatic put_addr(input logic [7:0] a, input logic sel);
    cs_n = sel; ad_in = a; as_pin = 1'b1; step(4);
    as_pin = 1'b0; step(4);
  endtask

  task automatic bus_write(input logic m, input logic [7:0] a, input logic [7:0] d,
                           input logic sel, input bit expect_it, input string req);
    put_addr(a, sel);
    ad_in = d; rw_pin = 1'b0; step(4);
    if (m) begin ds_pin = 1'b1; step(4); end
    if (expect_it) begin
      q_wa.push_back(a[6:0]); q_wd.push_back(d); q_wr.push_back(req);
      model[a[6:0]] = d;
    end
    if (m) ds_pin = 1'b0; else rw_pin = 1'b1;
    step(2);
    if (expect_it) begin
      check(wr_stb == 1'b0, "R10 early pulse", wr_stb, 0);
      step(1);
      check(wr_stb == 1'b1, "R10 pulse on third edge", wr_stb, 1);
      step(1);
    end else step(2);
    rw_pin = 1'b1; step(4);
    go_idle(m);
  endtask

  task automatic bus_read(input logic m, input logic [7:0] a, input logic sel,
                          input bit expect_it, input string req);
    put_addr(a, sel);
    if (expect_it) begin q_rd.push_back(model[a[6:0]]); q_rr.push_back(req); end
    if (m) begin rw_pin = 1'b1; ds_pin = 1'b1; end else ds_pin = 1'b0;
    step(6);
    check(ad_oe == expect_it, {req, " drive level"}, ad_oe, expect_it);
    ds_pin = m ? 1'b0 : 1'b1; step(4);
    check(ad_oe == 1'b0, "R9 released after read", ad_oe, 0);
    go_idle(m);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    rst_n = 1'b0; pwr_fail = 1'b0; ad_in = 8'h00;
    mode_mot = 1'b1; cs_n = 1'b1; as_pin = 1'b0; ds_pin = 1'b0; rw_pin = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    check(ad_oe == 1'b0, "R9 reset oe", ad_oe, 0);
    check(wr_stb == 1'b0, "R9 reset strobe", wr_stb, 0);
    step(4);
    mon_on = 1'b1;

    // R1, R3, R4, R9: strobe plus level mode
    go_idle(1'b1);
    bus_read (1'b1, 8'h10, 1'b0, 1, "R9 reset content");
    bus_write(1'b1, 8'h10, 8'hA5, 1'b0, 1, "R4 write");
    bus_write(1'b1, 8'h7F, 8'h3C, 1'b0, 1, "R4 top address");
    bus_read (1'b1, 8'h10, 1'b0, 1, "R3 read");
    bus_read (1'b1, 8'h7F, 1'b0, 1, "R3 read top");
    bus_write(1'b1, 8'h85, 8'h5A, 1'b0, 1, "R2 bit7 ignored");
    bus_read (1'b1, 8'h05, 1'b0, 1, "R2 read aliased");
    // R7: deselected
    bus_write(1'b1, 8'h10, 8'hFF, 1'b1, 0, "R7 write");
    bus_read (1'b1, 8'h10, 1'b1, 0, "R7 read");
    bus_read (1'b1, 8'h10, 1'b0, 1, "R7 content kept");

    // R1, R5, R6: separate strobes
    go_idle(1'b0);
    bus_read (1'b0, 8'h7F, 1'b0, 1, "R5 read");
    bus_write(1'b0, 8'h22, 8'h81, 1'b0, 1, "R6 write");
    bus_write(1'b0, 8'h00, 8'h0F, 1'b0, 1, "R6 bottom address");
    bus_read (1'b0, 8'h22, 1'b0, 1, "R5 read back");
    bus_read (1'b0, 8'h00, 1'b0, 1, "R5 read bottom");
    bus_write(1'b0, 8'h22, 8'hEE, 1'b1, 0, "R7 write");
    bus_read (1'b0, 8'h22, 1'b0, 1, "R7 content kept");

    // R8: power fail in both modes
    pwr_fail = 1'b1;
    bus_write(1'b0, 8'h22, 8'h11, 1'b0, 0, "R8 write");
    bus_read (1'b0, 8'h22, 1'b0, 0, "R8 read");
    go_idle(1'b1);
    bus_write(1'b1, 8'h10, 8'h11, 1'b0, 0, "R8 write");
    bus_read (1'b1, 8'h10, 1'b0, 0, "R8 read");
    pwr_fail = 1'b0; step(4);
    bus_read (1'b1, 8'h10, 1'b0, 1, "R8 content kept");
    go_idle(1'b0);
    bus_read (1'b0, 8'h22, 1'b0, 1, "R8 content kept");

    step(8);
    check(q_wa.size() == 0, "R4/R6 missing write", q_wa.size(), 0);
    check(q_rd.size() == 0, "R3/R5 missing drive", q_rd.size(), 0);
    finish_run();
  end
endmodule